// File: doc/BRIEF.md
# Interrupt Destination Router and Arbiter

This block takes one interrupt message and decides which of N local interrupt agents receive it. A request carries a vector, an 8-bit destination, a 3-bit delivery mode, a bit that selects physical or logical addressing, a 2-bit shorthand and the sender's own ID. Each agent continuously presents its ID, its logical destination value, its destination format nibble, its arbitration priority and a focus flag. The focus flag is raised when the agent already holds the vector pending or in service and its focus checking is enabled.

Addressing is resolved in one combinational pass. This pass covers physical match and physical broadcast, logical flat and logical cluster match, and the three shorthands. It then applies the lowest-priority selection, which is the focus shortcut followed by a minimum-priority search. The result is registered. One cycle after a request strobe, the block drives one deliver strobe per chosen agent, the vector and delivery mode, and either an accepted flag or a send-accept error. The block holds no state between requests.

Top module: `irq_route_top`

## Requirements
- R1: With shorthand 0 and physical mode, a destination of 0xFF strobes every agent. Any other destination strobes each agent whose ID equals the destination.
- R2: With shorthand 0 and logical mode, a destination of 0x00 strobes no agent and reports not accepted.
- R3: In logical mode, an agent whose format nibble is 0xF matches when the destination ANDed with its logical value is nonzero.
- R4: In logical mode, an agent whose format nibble is 0x0 matches a destination of 0xFF. Otherwise it matches only when the upper nibbles of the destination and its logical value are equal and the AND of the lower nibbles is nonzero. Any other format nibble never matches.
- R5: In lowest-priority mode (delivery mode 3'b001), a matching agent with its focus flag set wins, whatever the priorities. Among several such agents, the lowest index wins. A focus flag on an agent that does not match has no effect.
- R6: In lowest-priority mode with no focused matching agent, the matching agent with the numerically smallest priority wins. On equal priorities the lowest index wins. Exactly one agent is strobed when any agent matches.
- R7: Lowest-priority mode with shorthand 0 in physical mode strobes no agent and reports not accepted.
- R8: Shorthand 1 strobes the agent whose ID equals the sender ID. Shorthand 2 strobes every agent. Shorthand 3 strobes every agent whose ID differs from the sender ID. Destination and addressing mode are ignored when the shorthand is not 0.
- R9: In lowest-priority mode with shorthand 2 or 3, arbitration runs over the set chosen by the shorthand.
- R10: For each request, exactly one of accepted and send-error is high. Accepted is high when at least one agent is strobed.
- R11: Strobes, accepted, send-error, vector and mode appear on the cycle after the request strobe and last one cycle. With no request, all strobes and flags are low.
- R12: Under reset, all strobes and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one message per high cycle |
| req_vector | input | VEC_W | Interrupt vector |
| req_dest | input | ID_W | Destination field |
| req_dmode | input | 3 | Delivery mode (3'b001 = lowest priority) |
| req_logical | input | 1 | 1 = logical addressing, 0 = physical |
| req_shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but sender |
| req_self_id | input | ID_W | ID of the sending agent |
| agt_id | input | N_AGENTS*ID_W | Agent IDs, agent 0 in the low bits |
| agt_ldr | input | N_AGENTS*ID_W | Agent logical destination values |
| agt_fmt | input | N_AGENTS*4 | Agent destination format nibbles |
| agt_prio | input | N_AGENTS*PRIO_W | Agent arbitration priorities |
| agt_focus | input | N_AGENTS | Agent focus flags |
| dlv_strobe | output | N_AGENTS | Per-agent deliver strobe |
| dlv_vector | output | VEC_W | Vector that goes with the strobes |
| dlv_mode | output | 3 | Delivery mode that goes with the strobes |
| accepted | output | 1 | At least one agent was strobed |
| send_err | output | 1 | No agent accepted the request |

## Verification
The focus shortcut and the minimum-priority search both evaluate in the same cycle on every lowest-priority request. The bench sets up requests where a focused agent has a worse priority than another matching agent, and checks that the focused agent alone is strobed. The shorthand exclusion and the arbitration also meet in one cycle. A request with the all-but-sender shorthand is made where the sender holds the best priority, and the bench judges that the next-best agent wins.

// File: rtl/irq_route_pkg.sv
// Package: shared encodings for the interrupt router.
// Assumes delivery-mode and shorthand encodings fixed by the message format.
package irq_route_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    localparam logic [1:0] SH_NONE     = 2'd0;
    localparam logic [1:0] SH_SELF     = 2'd1;
    localparam logic [1:0] SH_ALL      = 2'd2;
    localparam logic [1:0] SH_ALL_BUT  = 2'd3;

    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/irq_dest_match.sv
// Module: irq_dest_match
// Decides whether one agent belongs to the addressed set of a request.
// Assumes: ID_W is even (cluster split into halves); broadcast ID is all ones.
module irq_dest_match
    import irq_route_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] dest,
    input  logic            logical,
    input  logic [1:0]      shorthand,
    input  logic [ID_W-1:0] self_id,
    input  logic [ID_W-1:0] my_id,
    input  logic [ID_W-1:0] my_ldr,
    input  logic [3:0]      my_fmt,
    output logic            hit
);

    localparam int HALF = ID_W / 2;
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic flat_hit;
    logic clus_hit;
    logic log_hit;
    logic phys_hit;

    // Logical flat and cluster comparisons against this agent's register.
    always_comb begin
        flat_hit = |(dest & my_ldr);
        clus_hit = (dest == BCAST) ||
                   ((dest[ID_W-1:HALF] == my_ldr[ID_W-1:HALF]) &&
                    (|(dest[HALF-1:0] & my_ldr[HALF-1:0])));
        if (dest == '0)
            log_hit = 1'b0;
        else if (my_fmt == FMT_FLAT)
            log_hit = flat_hit;
        else if (my_fmt == FMT_CLUSTER)
            log_hit = clus_hit;
        else
            log_hit = 1'b0;
        phys_hit = (dest == BCAST) || (dest == my_id);
    end

    // Shorthand selection overrides the destination field.
    always_comb begin
        unique case (shorthand)
            SH_NONE:    hit = logical ? log_hit : phys_hit;
            SH_SELF:    hit = (my_id == self_id);
            SH_ALL:     hit = 1'b1;
            default:    hit = (my_id != self_id);
        endcase
    end

endmodule

// File: rtl/irq_lowpri_arb.sv
// Module: irq_lowpri_arb
// Picks one agent among candidates: focused candidate first (lowest index),
// else smallest priority with ties going to the lowest index.
// Assumes: purely combinational; grant is zero when no candidate exists.
module irq_lowpri_arb #(
    parameter int N_AGENTS = 4,
    parameter int PRIO_W   = 8
) (
    input  logic [N_AGENTS-1:0]        cand,
    input  logic [N_AGENTS-1:0]        focus,
    input  logic [N_AGENTS*PRIO_W-1:0] prio,
    output logic [N_AGENTS-1:0]        grant
);

    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

    logic [N_AGENTS-1:0] focus_pick;
    logic [N_AGENTS-1:0] low_pick;
    logic                focus_found;
    logic                have_best;
    logic [PRIO_W-1:0]   best_prio;
    logic [IDX_W-1:0]    best_idx;

    // Focus shortcut: first candidate that already owns the vector.
    always_comb begin
        focus_pick  = '0;
        focus_found = 1'b0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (cand[i] && focus[i] && !focus_found) begin
                focus_pick[i] = 1'b1;
                focus_found   = 1'b1;
            end
        end
    end

    // Minimum-priority search, strict less-than keeps the lowest index on ties.
    always_comb begin
        have_best = 1'b0;
        best_prio = '1;
        best_idx  = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (cand[i] && (!have_best || (prio[i*PRIO_W +: PRIO_W] < best_prio))) begin
                have_best = 1'b1;
                best_prio = prio[i*PRIO_W +: PRIO_W];
                best_idx  = IDX_W'(i);
            end
        end
        low_pick = '0;
        if (have_best)
            low_pick[best_idx] = 1'b1;
    end

    // Focus result takes precedence over the priority search.
    always_comb begin
        grant = focus_found ? focus_pick : low_pick;
    end

endmodule

// File: rtl/irq_route_top.sv
// Module: irq_route_top
// Routes one interrupt message per request strobe to N agents and registers
// the deliver strobes, vector, mode, accepted and send-error for one cycle.
// Assumes: agent inputs are stable in the request cycle; no state is kept
// between requests.
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int ID_W     = 8,
    parameter int VEC_W    = 8,
    parameter int PRIO_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VEC_W-1:0]           req_vector,
    input  logic [ID_W-1:0]            req_dest,
    input  logic [2:0]                 req_dmode,
    input  logic                       req_logical,
    input  logic [1:0]                 req_shorthand,
    input  logic [ID_W-1:0]            req_self_id,
    input  logic [N_AGENTS*ID_W-1:0]   agt_id,
    input  logic [N_AGENTS*ID_W-1:0]   agt_ldr,
    input  logic [N_AGENTS*4-1:0]      agt_fmt,
    input  logic [N_AGENTS*PRIO_W-1:0] agt_prio,
    input  logic [N_AGENTS-1:0]        agt_focus,
    output logic [N_AGENTS-1:0]        dlv_strobe,
    output logic [VEC_W-1:0]           dlv_vector,
    output logic [2:0]                 dlv_mode,
    output logic                       accepted,
    output logic                       send_err
);

    logic [N_AGENTS-1:0] cand;
    logic [N_AGENTS-1:0] grant;
    logic [N_AGENTS-1:0] sel;
    logic                lowpri;
    logic                drop;

    // One address matcher per agent.
    for (genvar g = 0; g < N_AGENTS; g++) begin : g_match
        irq_dest_match #(.ID_W(ID_W)) u_match (
            .dest      (req_dest),
            .logical   (req_logical),
            .shorthand (req_shorthand),
            .self_id   (req_self_id),
            .my_id     (agt_id[g*ID_W +: ID_W]),
            .my_ldr    (agt_ldr[g*ID_W +: ID_W]),
            .my_fmt    (agt_fmt[g*4 +: 4]),
            .hit       (cand[g])
        );
    end

    irq_lowpri_arb #(.N_AGENTS(N_AGENTS), .PRIO_W(PRIO_W)) u_arb (
        .cand  (cand),
        .focus (agt_focus),
        .prio  (agt_prio),
        .grant (grant)
    );

    // Final target set: drop physical lowest-priority, else arbitrate or fan out.
    always_comb begin
        lowpri = (req_dmode == DM_LOWEST);
        drop   = lowpri && !req_logical && (req_shorthand == SH_NONE);
        if (drop)
            sel = '0;
        else if (lowpri)
            sel = grant;
        else
            sel = cand;
    end

    // Register the result for exactly one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_strobe <= '0;
            dlv_vector <= '0;
            dlv_mode   <= '0;
            accepted   <= 1'b0;
            send_err   <= 1'b0;
        end else begin
            dlv_strobe <= req_valid ? sel : '0;
            accepted   <= req_valid && (|sel);
            send_err   <= req_valid && !(|sel);
            if (req_valid) begin
                dlv_vector <= req_vector;
                dlv_mode   <= req_dmode;
            end
        end
    end

    AST_ACC_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (accepted ^ send_err)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (dlv_strobe == '0 && !accepted && !send_err)); // R11

    AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lowpri) |=> $onehot0(dlv_strobe)); // R6

    AST_PHYS_LOWPRI_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && drop) |=> (dlv_strobe == '0 && send_err)); // R7

    AST_STROBE_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((dlv_strobe & ~$past(cand)) == '0)); // R3

    AST_LOG_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_logical && req_shorthand == SH_NONE && req_dest == '0)
        |=> !accepted); // R2

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~cand) == '0)); // R5

endmodule

// File: tb/sim_irq_route_top.sv
`timescale 1ns/1ps
module sim_irq_route_top;

    localparam int N = 4;

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  dest;
        logic [2:0]  dmode;
        logic        logical;
        logic [1:0]  sh;
        logic [7:0]  self_id;
        logic [3:0]  fmt;
        logic [31:0] ldr;
        logic [31:0] prio;
        logic [3:0]  focus;
        logic [3:0]  exp_stb;
        logic        exp_acc;
    } vec_t;

    localparam int NV = 19;
    localparam logic [31:0] FLAT_LDR = 32'h08040201;
    localparam logic [31:0] CLUS_LDR = 32'h22211211;
    localparam logic [31:0] PRIO_A   = 32'h20302040;

    localparam vec_t TBL [NV] = '{
        '{4'd1,  8'h03, 3'd0, 1'b0, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0100, 1'b1}, // R1
        '{4'd1,  8'hFF, 3'd0, 1'b0, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b1111, 1'b1}, // R1
        '{4'd10, 8'h09, 3'd0, 1'b0, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0000, 1'b0}, // R10
        '{4'd3,  8'h05, 3'd0, 1'b1, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0101, 1'b1}, // R3
        '{4'd2,  8'h00, 3'd0, 1'b1, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0000, 1'b0}, // R2
        '{4'd4,  8'h13, 3'd0, 1'b1, 2'd0, 8'h00, 4'h0, CLUS_LDR, PRIO_A, 4'h0, 4'b0011, 1'b1}, // R4
        '{4'd4,  8'hFF, 3'd0, 1'b1, 2'd0, 8'h00, 4'h0, CLUS_LDR, PRIO_A, 4'h0, 4'b1111, 1'b1}, // R4
        '{4'd4,  8'h20, 3'd0, 1'b1, 2'd0, 8'h00, 4'h0, CLUS_LDR, PRIO_A, 4'h0, 4'b0000, 1'b0}, // R4
        '{4'd4,  8'hFF, 3'd0, 1'b1, 2'd0, 8'h00, 4'h5, FLAT_LDR, PRIO_A, 4'h0, 4'b0000, 1'b0}, // R4
        '{4'd6,  8'h0F, 3'd1, 1'b1, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0010, 1'b1}, // R6
        '{4'd5,  8'h0F, 3'd1, 1'b1, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h8, 4'b1000, 1'b1}, // R5
        '{4'd5,  8'h07, 3'd1, 1'b1, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h8, 4'b0010, 1'b1}, // R5
        '{4'd7,  8'h02, 3'd1, 1'b0, 2'd0, 8'h00, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0000, 1'b0}, // R7
        '{4'd8,  8'h00, 3'd0, 1'b0, 2'd1, 8'h03, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0100, 1'b1}, // R8
        '{4'd8,  8'h00, 3'd0, 1'b1, 2'd2, 8'h03, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b1111, 1'b1}, // R8
        '{4'd8,  8'h09, 3'd0, 1'b0, 2'd3, 8'h01, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b1110, 1'b1}, // R8
        '{4'd9,  8'h00, 3'd1, 1'b0, 2'd3, 8'h02, 4'hF, FLAT_LDR, 32'h20301040, 4'h0, 4'b1000, 1'b1}, // R9
        '{4'd9,  8'h00, 3'd1, 1'b0, 2'd2, 8'h02, 4'hF, FLAT_LDR, 32'h10101010, 4'h0, 4'b0001, 1'b1}, // R9
        '{4'd10, 8'h00, 3'd0, 1'b0, 2'd1, 8'h09, 4'hF, FLAT_LDR, PRIO_A, 4'h0, 4'b0000, 1'b0}  // R10
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [7:0]   req_vector = '0;
    logic [7:0]   req_dest = '0;
    logic [2:0]   req_dmode = '0;
    logic         req_logical = 1'b0;
    logic [1:0]   req_shorthand = '0;
    logic [7:0]   req_self_id = '0;
    logic [31:0]  agt_id = 32'h04030201;
    logic [31:0]  agt_ldr = FLAT_LDR;
    logic [15:0]  agt_fmt = 16'hFFFF;
    logic [31:0]  agt_prio = PRIO_A;
    logic [3:0]   agt_focus = '0;
    logic [3:0]   dlv_strobe;
    logic [7:0]   dlv_vector;
    logic [2:0]   dlv_mode;
    logic         accepted;
    logic         send_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_route_top #(.N_AGENTS(N), .ID_W(8), .VEC_W(8), .PRIO_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_dest(req_dest), .req_dmode(req_dmode), .req_logical(req_logical),
        .req_shorthand(req_shorthand), .req_self_id(req_self_id), .agt_id(agt_id),
        .agt_ldr(agt_ldr), .agt_fmt(agt_fmt), .agt_prio(agt_prio), .agt_focus(agt_focus),
        .dlv_strobe(dlv_strobe), .dlv_vector(dlv_vector), .dlv_mode(dlv_mode),
        .accepted(accepted), .send_err(send_err)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: outputs low under reset
        check("R12 reset", {dlv_strobe, accepted, send_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: idle after reset
        check("R11 idle", {dlv_strobe, accepted, send_err}, '0);

        for (int i = 0; i < NV; i++) begin
            req_dest      = TBL[i].dest;
            req_dmode     = TBL[i].dmode;
            req_logical   = TBL[i].logical;
            req_shorthand = TBL[i].sh;
            req_self_id   = TBL[i].self_id;
            agt_fmt       = {4{TBL[i].fmt}};
            agt_ldr       = TBL[i].ldr;
            agt_prio      = TBL[i].prio;
            agt_focus     = TBL[i].focus;
            req_vector    = 8'h30 + 8'(i);
            req_valid     = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d vec%0d strobe", TBL[i].req, i),
                  16'(dlv_strobe), 16'(TBL[i].exp_stb));
            check($sformatf("R%0d vec%0d acc/err", TBL[i].req, i),
                  {14'd0, accepted, send_err}, {14'd0, TBL[i].exp_acc, !TBL[i].exp_acc});
            check($sformatf("R11 vec%0d vector/mode", i),
                  {5'd0, dlv_mode, dlv_vector}, {5'd0, TBL[i].dmode, 8'h30 + 8'(i)});
        end

        // R11: strobe lasts one cycle
        @(negedge clk);
        check("R11 single cycle", {dlv_strobe, accepted, send_err}, '0);

        // R11: back-to-back requests each appear on their own cycle
        req_dmode = 3'd0; req_logical = 1'b0; req_shorthand = 2'd0;
        req_dest = 8'h01; req_valid = 1'b1;
        @(negedge clk);
        check("R11 back-to-back first", 16'(dlv_strobe), 16'h1);
        req_dest = 8'h04;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 back-to-back second", 16'(dlv_strobe), 16'h8);

        // R5: two focused candidates, lowest index wins despite worse priority
        req_dmode = 3'd1; req_logical = 1'b1; req_dest = 8'h0F;
        agt_fmt = 16'hFFFF; agt_ldr = FLAT_LDR;
        agt_prio = 32'h01017070; agt_focus = 4'b0110;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 focus over priority", 16'(dlv_strobe), 16'h2);

        // R12: reset in the middle of a request clears outputs
        agt_focus = 4'b0; req_dmode = 3'd0; req_logical = 1'b0; req_dest = 8'hFF;
        req_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset with request", {dlv_strobe, accepted, send_err}, '0);
        req_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule